// File: doc/BRIEF.md
# Bidirectional Inter-Processor Word Mailbox

The block joins two processors, side A and side B, that share one clock. Each side owns an outgoing queue of 32-bit words. A write to that side's send register appends a word to the queue. The peer removes words in arrival order by reading its own receive register. So the two queues carry traffic in opposite directions, and each queue is the transmit path of one side and the receive path of the other.

Each side has a control register. It reports the fill state of both the queue the side feeds and the queue it drains. Through the same register, software sets two interrupt enables and a master enable, empties its own outgoing queue with one write, and clears a sticky error flag. The error flag records a push into a full queue or a pop from an empty one. Each side drives one level-sensitive interrupt line.

Each side reaches its registers through a two-bit word offset:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | send (reads as zero) |
| 2 | receive |
| 3 | unused (reads as zero, writes ignored) |

A register is read through a combinational read port. A receive read removes a word at the clock edge on which the read strobe is high.

Top module: `ipc_fifo_pair`

## Requirements
- R1: After reset, both queues are empty and every enable and the error flag are 0. Each control register then reads 0x0000_0101, and both interrupt lines are low.
- R2: While a side's master enable (control bit 15) is 1, a write to offset 1 appends the word to its outgoing queue when that queue is not full. The peer reads the words back at offset 2 in the order they were written, one per receive read.
- R3: Control bit 0 reads 1 while the side's outgoing queue is empty, and bit 1 reads 1 while it holds DEPTH (16) words. Bit 8 reads 1 while the side's incoming queue is empty, and bit 9 reads 1 while it holds DEPTH words.
- R4: While enabled, a write to offset 1 when the outgoing queue is full is discarded, and it sets error bit 14 of that side's control register.
- R5: While enabled, a read of offset 2 when the incoming queue is empty removes nothing. It returns the last word that was removed from that queue (0 if none), and it sets error bit 14.
- R6: Error bit 14 stays at 1 until a control write with bit 14 set. A control write with bit 14 clear leaves the error bit unchanged.
- R7: A control write with bit 3 set empties the side's outgoing queue within that single clock edge. Afterwards the writer's bit 0 and the peer's bit 8 both read 1. Bit 3 always reads 0, and a control write with bit 3 clear does not change the queue.
- R8: While a side's master enable is 0, its writes to offset 1 and reads of offset 2 move no data and set no error.
- R9: A side's interrupt line is high while its control bit 2 is 1 and its outgoing queue is empty.
- R10: A side's interrupt line is high while its control bit 10 is 1 and its incoming queue holds at least one word.
- R11: The two directions work independently. Traffic from A to B and from B to A can be outstanding at the same time without either changing the other.
- R12: Control bits 2, 10 and 15 read back the value last written. Every control bit other than 0, 1, 2, 8, 9, 10, 14 and 15 reads 0. Offsets 1 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe (pops on receive offset) |
| a_addr | input | 2 | Side A word offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (combinational) |
| a_irq | output | 1 | Side A interrupt, level |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe (pops on receive offset) |
| b_addr | input | 2 | Side B word offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (combinational) |
| b_irq | output | 1 | Side B interrupt, level |

## Verification
The properties assume that a side never writes and reads in the same cycle. The one shared offset per side makes any such pair ambiguous, and the error-clear and queue-count properties rely on this. The bench follows that rule: each task raises exactly one strobe for one clock edge and then lowers it. The bench also changes its inputs only on the falling edge, so each property sees one stable access per cycle.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

    parameter int unsigned DEF_DATA_W = 32;
    parameter int unsigned DEF_DEPTH  = 16;

    // Word offsets seen by software on each side.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SEND = 2'd1,
        SEL_RECV = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Control register bit positions (software decodes these).
    localparam int unsigned CB_TX_EMPTY = 0;
    localparam int unsigned CB_TX_FULL  = 1;
    localparam int unsigned CB_TX_IEN   = 2;
    localparam int unsigned CB_FLUSH    = 3;
    localparam int unsigned CB_RX_EMPTY = 8;
    localparam int unsigned CB_RX_FULL  = 9;
    localparam int unsigned CB_RX_IEN   = 10;
    localparam int unsigned CB_ERR      = 14;
    localparam int unsigned CB_ENABLE   = 15;

    // Software-visible state kept per side.
    typedef struct packed {
        logic tx_ien;
        logic rx_ien;
        logic enable;
        logic err;
    } ctl_state_t;

    // Fill flags of one queue.
    typedef struct packed {
        logic full;
        logic empty;
    } q_flags_t;

    function automatic logic [15:0] pack_ctrl(input ctl_state_t c,
                                              input q_flags_t tx,
                                              input q_flags_t rx);
        logic [15:0] v;
        v              = '0;
        v[CB_TX_EMPTY] = tx.empty;
        v[CB_TX_FULL]  = tx.full;
        v[CB_TX_IEN]   = c.tx_ien;
        v[CB_RX_EMPTY] = rx.empty;
        v[CB_RX_FULL]  = rx.full;
        v[CB_RX_IEN]   = c.rx_ien;
        v[CB_ERR]      = c.err;
        v[CB_ENABLE]   = c.enable;
        return v;
    endfunction

endpackage

// File: rtl/ipf_fifo.sv
module ipf_fifo #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic [DATA_W-1:0] last,
    output ipf_pkg::q_flags_t flags,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign flags.empty = (cnt == '0);
    assign flags.full  = (cnt == CNT_W'(DEPTH));
    assign do_push     = push && !flags.full && !flush;
    assign do_pop      = pop && !flags.empty && !flush;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            last <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= bump(wp);
            end
            if (do_pop) begin
                rp   <= bump(rp);
                last <= mem[rp];
            end
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head  = mem[rp];
    assign count = cnt;

endmodule

// File: rtl/ipf_side.sv
module ipf_side #(
    parameter int unsigned DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  ipf_pkg::q_flags_t   tx_flags,
    input  ipf_pkg::q_flags_t   rx_flags,
    input  logic [DATA_W-1:0]   rx_head,
    input  logic [DATA_W-1:0]   rx_last,
    output logic [DATA_W-1:0]   rdata,
    output logic                push,
    output logic                pop,
    output logic                flush,
    output logic                irq,
    output ipf_pkg::ctl_state_t ctl
);
    import ipf_pkg::*;

    reg_sel_e sel;
    logic     wr_ctrl, want_send, want_recv, overflow, underflow;

    assign sel       = reg_sel_e'(addr);
    assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
    assign want_send = wr_en && (sel == SEL_SEND) && ctl.enable;
    assign want_recv = rd_en && (sel == SEL_RECV) && ctl.enable;

    assign push      = want_send && !tx_flags.full;
    assign overflow  = want_send && tx_flags.full;
    assign pop       = want_recv && !rx_flags.empty;
    assign underflow = want_recv && rx_flags.empty;
    assign flush     = wr_ctrl && wdata[CB_FLUSH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctl.tx_ien <= wdata[CB_TX_IEN];
                ctl.rx_ien <= wdata[CB_RX_IEN];
                ctl.enable <= wdata[CB_ENABLE];
            end
            if (overflow || underflow) begin
                ctl.err <= 1'b1;
            end else if (wr_ctrl && wdata[CB_ERR]) begin
                ctl.err <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = DATA_W'(pack_ctrl(ctl, tx_flags, rx_flags));
            SEL_RECV: rdata = rx_flags.empty ? rx_last : rx_head;
            default:  rdata = '0;
        endcase
    end

    assign irq = (ctl.tx_ien && tx_flags.empty) || (ctl.rx_ien && !rx_flags.empty);

endmodule

// File: rtl/ipc_fifo_pair.sv
module ipc_fifo_pair #(
    parameter int unsigned DATA_W = ipf_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = ipf_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_wr_en,
    input  logic              a_rd_en,
    input  logic [1:0]        a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    input  logic              b_wr_en,
    input  logic              b_rd_en,
    input  logic [1:0]        b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq
);
    import ipf_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    // Index s: side s, and the queue that side s feeds.
    logic [1:0]              s_wr, s_rd, s_push, s_pop, s_flush, s_irq;
    logic [1:0][1:0]         s_addr;
    logic [1:0][DATA_W-1:0]  s_wdata, s_rdata, q_head, q_last;
    q_flags_t   [1:0]        q_flags;
    logic [1:0][CNT_W-1:0]   q_cnt;
    ctl_state_t [1:0]        s_ctl;

    assign s_wr    = {b_wr_en, a_wr_en};
    assign s_rd    = {b_rd_en, a_rd_en};
    assign s_addr  = {b_addr, a_addr};
    assign s_wdata = {b_wdata, a_wdata};
    assign a_rdata = s_rdata[0];
    assign b_rdata = s_rdata[1];
    assign a_irq   = s_irq[0];
    assign b_irq   = s_irq[1];

    for (genvar g = 0; g < 2; g++) begin : g_dir
        localparam int P = 1 - g;

        ipf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (s_push[g]),
            .pop   (s_pop[P]),
            .flush (s_flush[g]),
            .din   (s_wdata[g]),
            .head  (q_head[g]),
            .last  (q_last[g]),
            .flags (q_flags[g]),
            .count (q_cnt[g])
        );

        ipf_side #(.DATA_W(DATA_W)) u_side (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (s_wr[g]),
            .rd_en    (s_rd[g]),
            .addr     (s_addr[g]),
            .wdata    (s_wdata[g]),
            .tx_flags (q_flags[g]),
            .rx_flags (q_flags[P]),
            .rx_head  (q_head[P]),
            .rx_last  (q_last[P]),
            .rdata    (s_rdata[g]),
            .push     (s_push[g]),
            .pop      (s_pop[g]),
            .flush    (s_flush[g]),
            .irq      (s_irq[g]),
            .ctl      (s_ctl[g])
        );
    end

endmodule

// File: rtl/ipf_checker.sv
module ipf_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   wr,
    input logic [1:0]                   rd,
    input logic [1:0][1:0]              addr,
    input logic [1:0][DATA_W-1:0]       wdata,
    input ipf_pkg::q_flags_t [1:0]      flags,
    input logic [1:0][CNT_W-1:0]        cnt,
    input ipf_pkg::ctl_state_t [1:0]    ctl,
    input logic [1:0]                   irq
);
    for (genvar g = 0; g < 2; g++) begin : g_chk
        localparam int P = 1 - g;

        // R3: a queue is never both full and empty; full means DEPTH words
        a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(flags[g].full && flags[g].empty));
        a_r3_full_count: assert property (@(posedge clk) disable iff (rst)
            flags[g].full |-> (cnt[g] == CNT_W'(DEPTH)));

        // R4: push into a full queue raises error and adds nothing
        a_r4_overflow_err: assert property (@(posedge clk) disable iff (rst)
            (wr[g] && addr[g] == 2'd1 && ctl[g].enable && flags[g].full) |=> ctl[g].err);
        a_r4_overflow_drop: assert property (@(posedge clk) disable iff (rst)
            (wr[g] && addr[g] == 2'd1 && flags[g].full) |=> (cnt[g] <= $past(cnt[g])));

        // R5: pop from an empty queue raises error
        a_r5_underflow_err: assert property (@(posedge clk) disable iff (rst)
            (rd[g] && addr[g] == 2'd2 && ctl[g].enable && flags[P].empty) |=> ctl[g].err);

        // R6: control write with bit 14 set clears the error
        a_r6_err_clear: assert property (@(posedge clk) disable iff (rst)
            (wr[g] && !rd[g] && addr[g] == 2'd0 && wdata[g][14]) |=> !ctl[g].err);

        // R7: flush leaves the outgoing queue empty after one edge
        a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
            (wr[g] && addr[g] == 2'd0 && wdata[g][3]) |=> flags[g].empty);

        // R8: disabled side moves no data
        a_r8_no_send_off: assert property (@(posedge clk) disable iff (rst)
            (!ctl[g].enable && wr[g] && addr[g] == 2'd1) |=> (cnt[g] <= $past(cnt[g])));
        a_r8_no_recv_off: assert property (@(posedge clk) disable iff (rst)
            (!ctl[g].enable && rd[g] && addr[g] == 2'd2 &&
             !(wr[P] && addr[P] == 2'd0 && wdata[P][3])) |=> (cnt[P] >= $past(cnt[P])));

        // R9 / R10: level interrupt conditions
        a_r9_tx_irq: assert property (@(posedge clk) disable iff (rst)
            (ctl[g].tx_ien && flags[g].empty) |-> irq[g]);
        a_r10_rx_irq: assert property (@(posedge clk) disable iff (rst)
            (ctl[g].rx_ien && !flags[P].empty) |-> irq[g]);

        // R1: no enable, no interrupt
        a_r1_irq_quiet: assert property (@(posedge clk) disable iff (rst)
            (!ctl[g].tx_ien && !ctl[g].rx_ien) |-> !irq[g]);
    end
endmodule

bind ipc_fifo_pair ipf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr    (s_wr),
    .rd    (s_rd),
    .addr  (s_addr),
    .wdata (s_wdata),
    .flags (q_flags),
    .cnt   (q_cnt),
    .ctl   (s_ctl),
    .irq   (s_irq)
);

// File: tb/tb_ipc_fifo_pair.sv
`timescale 1ns/1ps
module tb_ipc_fifo_pair;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [1:0]       wr = '0, rd = '0;
    logic [1:0][1:0]  ad = '0;
    logic [1:0][31:0] wd = '0;
    logic [31:0]      rda, rdb;
    logic             irqa, irqb;

    ipc_fifo_pair dut (
        .clk(clk), .rst(rst),
        .a_wr_en(wr[0]), .a_rd_en(rd[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
        .a_rdata(rda), .a_irq(irqa),
        .b_wr_en(wr[1]), .b_rd_en(rd[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
        .b_rdata(rdb), .b_irq(irqb)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Reference model
    logic [31:0] q0[$], q1[$];
    logic [1:0]  m_en = '0, m_err = '0, m_tien = '0, m_rien = '0;
    logic [1:0][31:0] m_last = '0;

    function automatic int qsz(int s);
        return (s == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [31:0] exp_ctrl(int s);
        logic [31:0] v = '0;
        v[0]  = (qsz(s) == 0);
        v[1]  = (qsz(s) == DEPTH);
        v[2]  = m_tien[s];
        v[8]  = (qsz(1 - s) == 0);
        v[9]  = (qsz(1 - s) == DEPTH);
        v[10] = m_rien[s];
        v[14] = m_err[s];
        v[15] = m_en[s];
        return v;
    endfunction

    function automatic logic exp_irq(int s);
        return (m_tien[s] && qsz(s) == 0) || (m_rien[s] && qsz(1 - s) != 0);
    endfunction

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdv(int s);
        return (s == 0) ? rda : rdb;
    endfunction

    task automatic wreg(int s, logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr[s] = 1'b1; ad[s] = a; wd[s] = d;
        @(negedge clk);
        wr[s] = 1'b0;
    endtask

    task automatic rreg(int s, logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd[s] = 1'b1; ad[s] = a;
        #1 d = rdv(s);
        @(negedge clk);
        rd[s] = 1'b0;
    endtask

    task automatic peek(int s, logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        ad[s] = a;
        #1 d = rdv(s);
    endtask

    task automatic wctrl(int s, logic [31:0] v);
        wreg(s, 2'd0, v);
        m_tien[s] = v[2];
        m_rien[s] = v[10];
        m_en[s]   = v[15];
        if (v[3]) begin
            if (s == 0) q0.delete(); else q1.delete();
        end
        if (v[14]) m_err[s] = 1'b0;
    endtask

    // Driver: write a word, record what the peer should later see.
    task automatic send(int s, logic [31:0] d);
        wreg(s, 2'd1, d);
        if (m_en[s]) begin
            if (qsz(s) < DEPTH) begin
                if (s == 0) q0.push_back(d); else q1.push_back(d);
            end else begin
                m_err[s] = 1'b1;
            end
        end
    endtask

    // Monitor: pop a word and compare with the scoreboard.
    task automatic recv(int s, string req);
        logic [31:0] d, e;
        rreg(s, 2'd2, d);
        if (m_en[s]) begin
            if (qsz(1 - s) != 0) begin
                e = (s == 0) ? q1.pop_front() : q0.pop_front();
                m_last[1 - s] = e;
            end else begin
                e = m_last[1 - s];
                m_err[s] = 1'b1;
            end
            chk(req, "receive data", d, e);
        end
    endtask

    task automatic look(int s, string req);
        logic [31:0] d;
        peek(s, 2'd0, d);
        chk(req, s == 0 ? "ctrl A" : "ctrl B", d, exp_ctrl(s));
        chk(req, s == 0 ? "irq A" : "irq B", {31'b0, (s == 0) ? irqa : irqb}, {31'b0, exp_irq(s)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(0, 2'd0, d); chk("R1", "ctrl A", d, 32'h0000_0101);
        peek(1, 2'd0, d); chk("R1", "ctrl B", d, 32'h0000_0101);
        chk("R1", "irqs", {30'b0, irqb, irqa}, 32'h0);

        // R12: readback of writable bits, zero elsewhere
        wctrl(0, 32'hFFFF_BBF7); look(0, "R12");
        peek(0, 2'd1, d); chk("R12", "offset1", d, 32'h0);
        peek(0, 2'd3, d); chk("R12", "offset3", d, 32'h0);
        wctrl(0, 32'h0000_8000); wctrl(1, 32'h0000_8000);
        look(0, "R12"); look(1, "R12");

        // R2 / R11: both directions in flight
        send(0, 32'hA000_0001); send(1, 32'hB000_0001);
        send(0, 32'hA000_0002); send(0, 32'hA000_0003);
        send(1, 32'hB000_0002);
        look(0, "R11"); look(1, "R11");
        recv(1, "R2"); recv(0, "R11"); recv(1, "R2");
        recv(0, "R11"); recv(1, "R2");
        look(0, "R2"); look(1, "R2");

        // R3 / R4: fill and overflow
        for (int i = 0; i < DEPTH; i++) send(0, 32'hC0DE_0000 + 32'(i));
        look(0, "R3"); look(1, "R3");
        send(0, 32'hDEAD_BEEF);
        look(0, "R4"); look(1, "R4");

        // R6: error clears only on a 1 in bit 14
        wctrl(0, 32'h0000_8000); look(0, "R6");
        wctrl(0, 32'h0000_C000); look(0, "R6");
        for (int i = 0; i < DEPTH; i++) recv(1, "R4");
        look(1, "R3");

        // R5: empty read returns last word and flags error
        recv(1, "R5"); look(1, "R5");
        wctrl(1, 32'h0000_C000); look(1, "R6");

        // R7: flush
        for (int i = 0; i < 4; i++) send(0, 32'h7700_0000 + 32'(i));
        wctrl(0, 32'h0000_8000); look(1, "R7");
        wctrl(0, 32'h0000_8008); look(0, "R7"); look(1, "R7");
        recv(1, "R7"); wctrl(1, 32'h0000_C000);

        // R8: disabled side moves nothing
        wctrl(0, 32'h0000_0000);
        send(0, 32'h5555_0000); look(0, "R8"); look(1, "R8");
        send(1, 32'h8888_0001);
        recv(0, "R8"); look(0, "R8");
        wctrl(0, 32'h0000_8000); recv(0, "R8"); look(0, "R8");

        // R9 / R10: level interrupts
        wctrl(0, 32'h0000_8004); look(0, "R9");
        send(0, 32'h9999_0001); look(0, "R9");
        wctrl(1, 32'h0000_8400); look(1, "R10");
        recv(1, "R10"); look(1, "R10"); look(0, "R9");

        report();
    end

endmodule